// File: doc/BRIEF.md
# Keyed-Unlock Watchdog Timer

This watchdog sits on a single-cycle register bus and counts ticks of a tick-enable input. When the count reaches a programmed 16-bit limit, it raises a reset request. Software keeps it quiet by writing a refresh key to the count address, which restarts the count from zero. Configuration is protected by a separate unlock key written to the same address. After the unlock key, software has a 128-cycle window in which to write the control and limit registers. When the window ends, the registers lock again.

A configuration write does not take effect at once. It lands in shadow storage and is applied one cycle later, and a status bit shows that a change is still pending. The control word holds four settings: an enable, an interrupt enable that makes the expiry give an interrupt pulse before the reset request, a stored clock-select field, and a debug-run bit that decides whether counting continues while the core is halted. It also holds an update-allowed bit. Once that bit is cleared, no later unlock succeeds until reset.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the control/status word (address 0) reads 0x000000A0, the count (address 1) reads 0 and the limit (address 2) reads 0x0400. Both outputs are low. Control bit layout: bit0 enable, bit1 interrupt enable, bits3:2 clock select, bit4 debug-run, bit5 update-allowed, bit6 unlocked status (read-only), bit7 configuration-done status (read-only).
- R2: Writing 0xD928C520 to address 1 while update-allowed is 1 sets the unlocked bit from the next cycle. Writes to addresses 0 and 2 made while locked are ignored.
- R3: If the unlock key is written on edge e, writes on edges e+1 through e+128 are accepted. The unlocked bit reads 0 after edge e+128, and later configuration writes are ignored.
- R4: An accepted write to address 0 (bits 5:0) or to address 2 (low 16 bits) leaves the configuration-done bit at 0 for one cycle. On the next edge the new value becomes active and readable, the count restarts at 0, and the configuration-done bit returns to 1.
- R5: Writing 0xB480A602 to address 1 makes the count read 0 on the next cycle.
- R6: A write to address 1 of any other value leaves the count advancing as if no write had happened.
- R7: Once update-allowed is 0 and the window has closed, an unlock key write no longer sets the unlocked bit, and configuration writes are ignored until reset.
- R8: The count advances by one on each edge where enable and tick_en are both 1. It holds when either is 0.
- R9: While dbg_halt is 1 and debug-run is 0, the count holds. With debug-run at 1, it keeps advancing during dbg_halt.
- R10: On a counting edge where the count equals the limit, the count stops. Without interrupt enable, wdog_rst_req rises on that edge. With interrupt enable, wdog_irq is high for one cycle and wdog_rst_req rises on the following edge. wdog_rst_req then stays high until reset.
- R11: A refresh on the same edge as an expiry wins: the count goes to 0 and neither output is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, with bus_sel |
| bus_addr | input | 2 | Register address: 0 control/status, 1 count, 2 limit |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_en | input | 1 | Count tick qualifier |
| dbg_halt | input | 1 | Core halted in debug |
| wdog_irq | output | 1 | One-cycle pre-reset interrupt |
| wdog_rst_req | output | 1 | Sticky reset request |

## Verification
Two functions can act on the same edge: the refresh key write and the counting step that would reach the limit. The bench refreshes, lets the count climb to exactly the limit, and then places a second refresh on the edge where expiry would fire. It judges the outcome in three ways: the count must read 0, the reset request must stay low, and expiry must arrive a full limit period later, which shows that the refresh took priority.

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int                CNT_W       = 16,
  parameter int                WINDOW      = 128,
  parameter logic [31:0]       KEY_UNLOCK  = 32'hD928_C520,
  parameter logic [31:0]       KEY_REFRESH = 32'hB480_A602,
  parameter logic [CNT_W-1:0]  TOV_RST     = 'h0400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        tick_en,
  input  logic        dbg_halt,
  output logic        wdog_irq,
  output logic        wdog_rst_req
);
  localparam int         WIN_W  = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_TOV  = 2'd2;
  localparam logic [5:0] CTRL_RST = 6'b10_0000;

  logic             unlocked, pend;
  logic [WIN_W-1:0] win;
  logic [5:0]       s_ctrl, a_ctrl;
  logic [CNT_W-1:0] s_tov, tov, count;

  wire c_en  = a_ctrl[0];
  wire c_irq = a_ctrl[1];
  wire c_dbg = a_ctrl[4];
  wire c_upd = a_ctrl[5];

  wire wr          = bus_sel & bus_we;
  wire unlock_hit  = wr && bus_addr == A_CNT && bus_wdata == KEY_UNLOCK && c_upd;
  wire refresh_hit = wr && bus_addr == A_CNT && bus_wdata == KEY_REFRESH;
  wire ctrl_wr     = wr && bus_addr == A_CTRL && unlocked;
  wire tov_wr      = wr && bus_addr == A_TOV && unlocked;

  wire step = c_en && tick_en && !(dbg_halt && !c_dbg) && !wdog_irq && !wdog_rst_req;
  wire fire = step && count == tov && !refresh_hit && !pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked     <= 1'b0;
      win          <= '0;
      pend         <= 1'b0;
      s_ctrl       <= CTRL_RST;
      a_ctrl       <= CTRL_RST;
      s_tov        <= TOV_RST;
      tov          <= TOV_RST;
      count        <= '0;
      wdog_irq     <= 1'b0;
      wdog_rst_req <= 1'b0;
    end else begin
      if (unlock_hit) begin
        unlocked <= 1'b1;
        win      <= '0;
      end else if (unlocked) begin
        if (win == WIN_W'(WINDOW - 1)) unlocked <= 1'b0;
        else                           win      <= win + 1'b1;
      end

      if (ctrl_wr) s_ctrl <= bus_wdata[5:0];
      if (tov_wr)  s_tov  <= bus_wdata[CNT_W-1:0];
      pend <= ctrl_wr | tov_wr;
      if (pend) begin
        a_ctrl <= s_ctrl;
        tov    <= s_tov;
      end

      if (refresh_hit || pend)        count <= '0;
      else if (step && count != tov)  count <= count + 1'b1;

      wdog_irq     <= fire && c_irq;
      wdog_rst_req <= wdog_rst_req | wdog_irq | (fire && !c_irq);
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {24'b0, ~pend, unlocked, a_ctrl};
      A_CNT:   bus_rdata = 32'(count);
      A_TOV:   bus_rdata = 32'(tov);
      default: bus_rdata = '0;
    endcase
  end

  p_unlock_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(unlock_hit));

  p_window_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && win == WIN_W'(WINDOW - 1) && !unlock_hit) |=> !unlocked);

  p_refresh_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_hit |=> count == '0);

  p_locked_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_upd && !unlocked) |=> !unlocked);

  p_halt_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && !c_dbg && !refresh_hit && !pend) |=> $stable(count));

  p_rst_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_req |=> wdog_rst_req);

  p_irq_then_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_irq |=> (!wdog_irq && wdog_rst_req));

  p_refresh_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_hit && !wdog_rst_req && !wdog_irq) |=> (!wdog_rst_req && !wdog_irq));
endmodule

// File: tb/tb_wdog_keyed.sv
module tb_wdog_keyed;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KU = 32'hD928_C520;
  localparam logic [31:0] KR = 32'hB480_A602;
  localparam int NV = 14;
  // {op, addr, data}: op 0 write, 1 read-check, 2 idle data cycles
  localparam logic [35:0] VEC [NV] = '{
    {2'd0, 2'd1, KU},
    {2'd1, 2'd0, 32'h0000_00E0},
    {2'd0, 2'd2, 32'h0000_0010},
    {2'd1, 2'd0, 32'h0000_0060},
    {2'd1, 2'd2, 32'h0000_0400},
    {2'd2, 2'd0, 32'd1},
    {2'd1, 2'd0, 32'h0000_00E0},
    {2'd1, 2'd2, 32'h0000_0010},
    {2'd0, 2'd0, 32'h0000_003D},
    {2'd1, 2'd0, 32'h0000_0060},
    {2'd2, 2'd0, 32'd1},
    {2'd1, 2'd0, 32'h0000_00FD},
    {2'd0, 2'd1, 32'h1234_5678},
    {2'd1, 2'd0, 32'h0000_00FD}
  };

  logic clk = 0, rst_n = 0, bus_sel = 0, bus_we = 0, tick_en = 1, dbg_halt = 0;
  logic [1:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic wdog_irq, wdog_rst_req;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_keyed dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .dbg_halt(dbg_halt), .wdog_irq(wdog_irq),
    .wdog_rst_req(wdog_rst_req));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 0; tick_en = 1; dbg_halt = 0;
    idle(2);
    rst_n = 1;
  endtask

  task automatic cfg(input logic [31:0] c, input logic [31:0] t);
    wr(2'd1, KU); wr(2'd2, t); wr(2'd0, c); idle(2);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    @(negedge clk);
    do_reset();

    rd(2'd0, v); chk("R1 ctrl", v, 32'h0000_00A0);
    rd(2'd1, v); chk("R1 count", v, 0);
    rd(2'd2, v); chk("R1 limit", v, 32'h0000_0400);
    chk("R1 outputs", {30'b0, wdog_irq, wdog_rst_req}, 0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][35:34])
        2'd0: wr(VEC[i][33:32], VEC[i][31:0]);
        2'd1: begin rd(VEC[i][33:32], v); chk("R2/R4 table", v, VEC[i][31:0]); end
        default: idle(int'(VEC[i][31:0]));
      endcase
    end

    // R2: config writes while locked are ignored
    do_reset();
    wr(2'd2, 32'h77); wr(2'd0, 32'h3F); idle(1);
    rd(2'd2, v); chk("R2 locked limit", v, 32'h400);
    rd(2'd0, v); chk("R2 locked ctrl", v, 32'hA0);

    // R8 enable/tick gating, R6 bogus key, R5 refresh
    do_reset();
    idle(10);
    rd(2'd1, v); chk("R8 disabled", v, 0);
    cfg(32'h21, 32'h400); wr(2'd1, KR);
    idle(5);
    rd(2'd1, v); chk("R8 counting", v, 5);
    tick_en = 0; idle(3);
    rd(2'd1, v); chk("R8 tick gated", v, 5);
    tick_en = 1;
    wr(2'd1, 32'h1);
    rd(2'd1, v); chk("R6 bogus write", v, 6);
    wr(2'd1, KR);
    rd(2'd1, v); chk("R5 refresh", v, 0);

    // R9 debug halt
    do_reset();
    cfg(32'h21, 32'h400); wr(2'd1, KR);
    idle(3);
    dbg_halt = 1; idle(4);
    rd(2'd1, v); chk("R9 frozen", v, 3);
    dbg_halt = 0; idle(2);
    rd(2'd1, v); chk("R9 resumed", v, 5);
    cfg(32'h31, 32'h400); wr(2'd1, KR);
    dbg_halt = 1; idle(4);
    rd(2'd1, v); chk("R9 debug-run", v, 4);
    dbg_halt = 0;

    // R10 expiry without interrupt
    do_reset();
    cfg(32'h21, 32'h8); wr(2'd1, KR);
    idle(8);
    rd(2'd1, v); chk("R10 at limit", v, 8);
    chk("R10 no early rst", {31'b0, wdog_rst_req}, 0);
    idle(1);
    chk("R10 rst", {30'b0, wdog_irq, wdog_rst_req}, 32'h1);
    rd(2'd1, v); chk("R10 count stops", v, 8);
    idle(3); wr(2'd1, KR);
    chk("R10 sticky", {31'b0, wdog_rst_req}, 1);

    // R10 expiry with interrupt
    do_reset();
    cfg(32'h23, 32'h8); wr(2'd1, KR);
    idle(9);
    chk("R10 irq first", {30'b0, wdog_irq, wdog_rst_req}, 32'h2);
    idle(1);
    chk("R10 rst after irq", {30'b0, wdog_irq, wdog_rst_req}, 32'h1);

    // R11 refresh on expiry edge
    do_reset();
    cfg(32'h21, 32'h8); wr(2'd1, KR);
    idle(8);
    wr(2'd1, KR);
    rd(2'd1, v); chk("R11 count", v, 0);
    chk("R11 no rst", {30'b0, wdog_irq, wdog_rst_req}, 0);
    idle(8);
    chk("R11 still quiet", {31'b0, wdog_rst_req}, 0);
    idle(1);
    chk("R11 later expiry", {31'b0, wdog_rst_req}, 1);

    // R3 window edges
    do_reset();
    wr(2'd1, KU); idle(127);
    wr(2'd2, 32'h55);
    rd(2'd0, v); chk("R3 relocked pending", v, 32'h20);
    idle(1);
    rd(2'd2, v); chk("R3 last write taken", v, 32'h55);
    wr(2'd2, 32'h66); idle(1);
    rd(2'd2, v); chk("R3 late write ignored", v, 32'h55);
    rd(2'd0, v); chk("R3 ctrl", v, 32'hA0);

    // R7 update lock
    do_reset();
    wr(2'd1, KU); wr(2'd0, 32'h01); idle(1);
    rd(2'd0, v); chk("R7 applied", v, 32'hC1);
    idle(130);
    rd(2'd0, v); chk("R7 relocked", v, 32'h81);
    wr(2'd1, KU);
    rd(2'd0, v); chk("R7 unlock refused", v, 32'h81);
    wr(2'd0, 32'h20); idle(1);
    rd(2'd0, v); chk("R7 ctrl kept", v, 32'h81);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule